// File: doc/BRIEF.md
# Ultra DMA Device Burst Engine

This block is the device-side sequencer for high-speed bursts on an ATA-style parallel disk interface. Several of the interface's control pins have one meaning during a burst and another outside it. The block decides when a burst is in force and gives each shared pin its role for the transfer direction. It then moves 16-bit words between the cable and an internal buffer, one word for each level change of the data strobe.

A burst starts only when the burst mode is enabled, a DMA data command is active, the device raises its request and the host acknowledges. On a data-in (read) transfer, the device drives the bus and toggles its own strobe. The host's pin then serves as the host's ready flag. On a data-out (write) transfer, the host drives the bus and toggles its strobe. The device's pin then serves as the device's ready flag.

Either side can end the burst. The host asserts its stop pin, or the device drops its internal request. The device then stops strobing, releases the bus and waits for the host to withdraw the acknowledge before it returns to idle. Host pins are brought into the local clock through a synchronizer. All pins are modelled active high, with 1 meaning asserted.

Top module: `udma_burst_dev`

## Requirements
- R1: While idle, pin_dmarq becomes 1 on the clock edge after udma_mode_en, cmd_dma_active and int_dma_req are all 1 (1 = asserted). If any of the three is 0, it stays 0.
- R2: burst_on becomes 1 on the third clock edge after pin_dmack rises while pin_dmarq is 1. This is two synchronizer stages plus the state register. burst_on stays 0 for as long as the acknowledge is absent.
- R3: On a read burst (cmd_dir_in = 1 when the request was raised), pin_data_oe is 1. A word taken with rd_pop appears on pin_data_out one edge later. pin_drdy_dstb changes level on the following edge. Each change, rising or falling, delivers exactly the next buffer word, in order.
- R4: On a read burst, while pin_hrdy_hstb (host ready) is 0, no word is popped and the strobe keeps its level. Transfer resumes once ready returns.
- R5: On a write burst (cmd_dir_in = 0), each level change of pin_hrdy_hstb (host strobe) produces exactly one wr_push pulse. The pulse carries the pin_data_in value present at that change, in arrival order.
- R6: During a write burst, pin_drdy_dstb (device ready) is 1 when wr_free is greater than 2 and 0 otherwise. It follows a change of wr_free after one edge.
- R7: When pin_stop is asserted during a burst, pin_dmarq drops and pin_data_oe and burst_on go to 0. The strobe then holds its level and no further word is popped. Every word popped before the stop has been strobed.
- R8: When int_dma_req drops during a burst, the block behaves as in R7: request withdrawn, bus released, strobe frozen and no further pops.
- R9: After pin_dmack is negated, the block is idle within three edges. burst_on and pin_drdy_dstb are then 0, and host strobe changes outside a write burst produce no wr_push.
- R10: reg_addr equals addr_pin[2:0] one edge later. addr_pin bits 10 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| udma_mode_en | input | 1 | Ultra DMA transfer mode selected |
| cmd_dma_active | input | 1 | A DMA read or write command needing data is active |
| cmd_dir_in | input | 1 | 1 = read (device to host), 0 = write |
| int_dma_req | input | 1 | Internal request to move data |
| addr_pin | input | 11 | Host address lines |
| reg_addr | output | 3 | Register select taken from the low address lines |
| pin_dmack | input | 1 | Host DMA acknowledge |
| pin_stop | input | 1 | Host stop request (burst meaning) |
| pin_hrdy_hstb | input | 1 | Host ready (read) or host strobe (write) |
| pin_data_in | input | 16 | Data bus as seen from the cable |
| pin_dmarq | output | 1 | Device DMA request |
| pin_drdy_dstb | output | 1 | Device strobe (read) or device ready (write) |
| pin_data_out | output | 16 | Data driven by the device |
| pin_data_oe | output | 1 | Device drives the data bus |
| burst_on | output | 1 | Burst meanings of the pins in force |
| rd_data | input | 16 | Head word of the outgoing buffer |
| rd_valid | input | 1 | Outgoing buffer holds a word |
| rd_pop | output | 1 | Take the head word from the outgoing buffer |
| wr_data | output | 16 | Word captured from the host |
| wr_push | output | 1 | wr_data is valid for one cycle |
| wr_free | input | 5 | Free entries in the incoming buffer |

## Verification
The properties assume that the host never toggles its strobe or changes data on a read burst, and never raises the acknowledge before the request. They also assume that rd_data stays stable while rd_valid is high and no pop occurs. The bench host model keeps to this. It holds each write word on the bus one clock before the strobe edge and keeps it there for three more clocks, so the synchronized data and strobe always agree. It withdraws the command and the internal request before dropping the acknowledge, and it changes buffer state only at the clock edge that consumes a pop.

// File: rtl/udma_burst_pkg.sv
package udma_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_DRAIN = 2'd3
  } burst_state_e;
endpackage

// File: rtl/udma_pin_sync.sv
module udma_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/udma_burst_ctrl.sv
module udma_burst_ctrl
  import udma_burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_en,
  input  logic         cmd_act,
  input  logic         cmd_in,
  input  logic         dev_req,
  input  logic         ack_s,
  input  logic         stop_s,
  input  logic         launch_busy,
  output burst_state_e state,
  output logic         dir_in,
  output logic         dmarq,
  output logic         halt
);
  logic go;
  assign go   = mode_en & cmd_act & dev_req;
  // a burst wants to end: host stop or device withdrawal
  assign halt = (state == ST_BURST) & (stop_s | ~dev_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      dmarq  <= 1'b0;
      dir_in <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state  <= ST_REQ;
            dmarq  <= 1'b1;
            dir_in <= cmd_in;
          end
        end
        ST_REQ: begin
          if (!go) begin
            state <= ST_IDLE;
            dmarq <= 1'b0;
          end else if (ack_s) begin
            state <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (!ack_s && !launch_busy) begin
            state <= ST_IDLE;
            dmarq <= 1'b0;
          end else if (halt && !launch_busy) begin
            state <= ST_DRAIN;
            dmarq <= 1'b0;
          end
        end
        ST_DRAIN: begin
          if (!ack_s) state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
          dmarq <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/udma_rd_launch.sv
module udma_rd_launch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              halt,
  input  logic              rdy,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_pop,
  output logic              busy,
  output logic              strobe,
  output logic [DATA_W-1:0] dout
);
  logic pend;

  // ready gates only the start of a new word; a loaded word always completes
  assign src_pop = run & ~halt & rdy & src_valid & ~pend;
  assign busy    = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      strobe <= 1'b0;
      dout   <= '0;
    end else if (clear) begin
      pend   <= 1'b0;
      strobe <= 1'b0;
    end else if (src_pop) begin
      dout <= src_data;
      pend <= 1'b1;
    end else if (pend) begin
      strobe <= ~strobe;
      pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/udma_wr_capture.sv
module udma_wr_capture #(
  parameter int DATA_W     = 16,
  parameter int FREE_W     = 5,
  parameter int PAUSE_FREE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic [FREE_W-1:0] free,
  output logic              push,
  output logic [DATA_W-1:0] word,
  output logic              ready
);
  logic stb_q;
  logic stb_edge;

  assign stb_edge = stb_s ^ stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      push  <= 1'b0;
      word  <= '0;
      ready <= 1'b0;
    end else begin
      stb_q <= stb_s;
      push  <= run & stb_edge;
      if (run && stb_edge) word <= data_s;
      ready <= run & (free > FREE_W'(PAUSE_FREE));
    end
  end
endmodule

// File: rtl/udma_burst_dev.sv
module udma_burst_dev
  import udma_burst_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 11,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FREE_W      = 5,
  parameter int PAUSE_FREE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              udma_mode_en,
  input  logic              cmd_dma_active,
  input  logic              cmd_dir_in,
  input  logic              int_dma_req,
  input  logic [ADDR_W-1:0] addr_pin,
  output logic [SEL_W-1:0]  reg_addr,
  input  logic              pin_dmack,
  input  logic              pin_stop,
  input  logic              pin_hrdy_hstb,
  input  logic [DATA_W-1:0] pin_data_in,
  output logic              pin_dmarq,
  output logic              pin_drdy_dstb,
  output logic [DATA_W-1:0] pin_data_out,
  output logic              pin_data_oe,
  output logic              burst_on,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              rd_pop,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_push,
  input  logic [FREE_W-1:0] wr_free
);
  localparam int SYNC_W = DATA_W + 3;

  logic [SYNC_W-1:0] sync_d, sync_q;
  logic              ack_s, stop_s, hpin_s;
  logic [DATA_W-1:0] data_s;
  burst_state_e      state;
  logic              dir_in, halt, launch_busy, dstb, ddmardy;
  logic              run_rd, run_wr, clear_rd;
  logic              unused_addr_hi;

  always_ff @(posedge clk) begin
    if (rst) reg_addr <= '0;
    else     reg_addr <= addr_pin[SEL_W-1:0];
  end
  assign unused_addr_hi = ^addr_pin[ADDR_W-1:SEL_W];

  assign sync_d = {pin_dmack, pin_stop, pin_hrdy_hstb, pin_data_in};

  udma_pin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(sync_d), .q(sync_q)
  );
  assign {ack_s, stop_s, hpin_s, data_s} = sync_q;

  udma_burst_ctrl i_ctrl (
    .clk(clk), .rst(rst), .mode_en(udma_mode_en), .cmd_act(cmd_dma_active),
    .cmd_in(cmd_dir_in), .dev_req(int_dma_req), .ack_s(ack_s), .stop_s(stop_s),
    .launch_busy(launch_busy), .state(state), .dir_in(dir_in), .dmarq(pin_dmarq),
    .halt(halt)
  );

  assign run_rd   = (state == ST_BURST) & dir_in;
  assign run_wr   = (state == ST_BURST) & ~dir_in;
  assign clear_rd = (state == ST_IDLE) | (state == ST_REQ);

  udma_rd_launch #(.DATA_W(DATA_W)) i_rd (
    .clk(clk), .rst(rst), .clear(clear_rd), .run(run_rd), .halt(halt),
    .rdy(hpin_s), .src_valid(rd_valid), .src_data(rd_data), .src_pop(rd_pop),
    .busy(launch_busy), .strobe(dstb), .dout(pin_data_out)
  );

  udma_wr_capture #(.DATA_W(DATA_W), .FREE_W(FREE_W), .PAUSE_FREE(PAUSE_FREE)) i_wr (
    .clk(clk), .rst(rst), .run(run_wr), .stb_s(hpin_s), .data_s(data_s),
    .free(wr_free), .push(wr_push), .word(wr_data), .ready(ddmardy)
  );

  assign burst_on    = (state == ST_BURST);
  assign pin_data_oe = run_rd;

  // device pin role: strobe on reads (held through drain), ready on writes
  always_comb begin
    if (dir_in)
      pin_drdy_dstb = ((state == ST_BURST) || (state == ST_DRAIN)) ? dstb : 1'b0;
    else
      pin_drdy_dstb = (state == ST_BURST) ? ddmardy : 1'b0;
  end
endmodule

// File: rtl/udma_burst_dev_chk.sv
module udma_burst_dev_chk #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 11,
  parameter int SEL_W      = 3,
  parameter int FREE_W     = 5,
  parameter int PAUSE_FREE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              udma_mode_en,
  input logic              cmd_dma_active,
  input logic              int_dma_req,
  input logic [ADDR_W-1:0] addr_pin,
  input logic [SEL_W-1:0]  reg_addr,
  input logic              pin_dmarq,
  input logic              pin_drdy_dstb,
  input logic [DATA_W-1:0] pin_data_out,
  input logic              pin_data_oe,
  input logic              burst_on,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_pop,
  input logic              wr_push,
  input logic [FREE_W-1:0] wr_free
);
  a_r1_req_needs_all: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_dmarq) |-> $past(udma_mode_en && cmd_dma_active && int_dma_req));

  a_r2_burst_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_on) |-> ($past(pin_dmarq) && pin_dmarq));

  a_r3_word_launch: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> (pin_data_out == $past(rd_data)));

  a_r4_strobe_after_pop: assert property (@(posedge clk) disable iff (rst)
    (pin_data_oe && $past(pin_data_oe) && (pin_drdy_dstb != $past(pin_drdy_dstb)))
      |-> $past(rd_pop, 2));

  a_r5_push_in_write: assert property (@(posedge clk) disable iff (rst)
    wr_push |-> $past(burst_on && !pin_data_oe));

  a_r6_ready_low: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !pin_data_oe && $past(burst_on) && ($past(wr_free) <= FREE_W'(PAUSE_FREE)))
      |-> !pin_drdy_dstb);

  a_r6_ready_high: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !pin_data_oe && $past(burst_on) && ($past(wr_free) > FREE_W'(PAUSE_FREE)))
      |-> pin_drdy_dstb);

  a_r7_no_pop_unrequested: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> pin_dmarq);

  a_r10_addr_low: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (reg_addr == $past(addr_pin[SEL_W-1:0])));
endmodule

bind udma_burst_dev udma_burst_dev_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .FREE_W(FREE_W), .PAUSE_FREE(PAUSE_FREE)
) i_chk (.*);

// File: tb/test_udma_burst_dev.sv
module test_udma_burst_dev;
  localparam int CLK_P    = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        udma_mode_en = 1'b0, cmd_dma_active = 1'b0, cmd_dir_in = 1'b0, int_dma_req = 1'b0;
  logic [10:0] addr_pin = '0;
  logic [2:0]  reg_addr;
  logic        pin_dmack = 1'b0, pin_stop = 1'b0, pin_hrdy_hstb = 1'b0;
  logic [15:0] pin_data_in = '0;
  logic        pin_dmarq, pin_drdy_dstb, pin_data_oe, burst_on;
  logic [15:0] pin_data_out;
  logic [15:0] rd_data;
  logic        rd_valid, rd_pop;
  logic [15:0] wr_data;
  logic        wr_push;
  logic [4:0]  wr_free = 5'd16;

  int n_chk = 0, n_fail = 0;
  int rd_idx = 0, rd_base = 0, rd_len = 0;
  int rx_cnt = 0, rx_base = 0;
  int wx_cnt = 0;
  bit mon_rd = 1'b0;
  logic last_stb = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] rdw(int k);
    return 16'(k * 263) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] wrw(int k);
    return 16'(k * 977) ^ 16'h1E2D;
  endfunction

  assign rd_valid = (rd_idx - rd_base) < rd_len;
  assign rd_data  = rdw(rd_idx - rd_base);

  udma_burst_dev i_udma_burst_dev (
    .clk(clk), .rst(rst), .udma_mode_en(udma_mode_en), .cmd_dma_active(cmd_dma_active),
    .cmd_dir_in(cmd_dir_in), .int_dma_req(int_dma_req), .addr_pin(addr_pin),
    .reg_addr(reg_addr), .pin_dmack(pin_dmack), .pin_stop(pin_stop),
    .pin_hrdy_hstb(pin_hrdy_hstb), .pin_data_in(pin_data_in), .pin_dmarq(pin_dmarq),
    .pin_drdy_dstb(pin_drdy_dstb), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
    .burst_on(burst_on), .rd_data(rd_data), .rd_valid(rd_valid), .rd_pop(rd_pop),
    .wr_data(wr_data), .wr_push(wr_push), .wr_free(wr_free)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outgoing buffer model: a pop seen at the edge consumes the head word
  always @(posedge clk) if (rd_pop) rd_idx <= rd_idx + 1;

  // host-side monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (pin_drdy_dstb !== last_stb) begin
      if (mon_rd) begin
        chk(pin_data_out == rdw(rx_cnt - rx_base), "R3 word order",
            int'(pin_data_out), int'(rdw(rx_cnt - rx_base)));
        rx_cnt++;
      end
      last_stb = pin_drdy_dstb;
    end
    if (wr_push) begin
      chk(wr_data == wrw(wx_cnt), "R5 write word", int'(wr_data), int'(wrw(wx_cnt)));
      wx_cnt++;
    end
  end

  task automatic enter(input bit dir_rd);
    cmd_dir_in = dir_rd; mon_rd = dir_rd;
    udma_mode_en = 1'b1; cmd_dma_active = 1'b1; int_dma_req = 1'b1;
    @(negedge clk);
    chk(pin_dmarq == 1'b1, "R1 request raised", int'(pin_dmarq), 1);
    repeat (3) @(negedge clk);
    chk(burst_on == 1'b0, "R2 no burst without ack", int'(burst_on), 0);
    pin_dmack = 1'b1;
    repeat (2) @(negedge clk);
    chk(burst_on == 1'b0, "R2 ack still in sync", int'(burst_on), 0);
    @(negedge clk);
    chk(burst_on == 1'b1, "R2 burst entered", int'(burst_on), 1);
    chk(pin_data_oe == dir_rd, "R3 bus drive by direction", int'(pin_data_oe), int'(dir_rd));
  endtask

  task automatic leave(input bit by_host, input bit poke);
    logic lvl;
    int   p, w;
    string tg;
    tg = by_host ? "R7" : "R8";
    if (by_host) pin_stop = 1'b1; else int_dma_req = 1'b0;
    for (int i = 0; i < 30 && pin_dmarq; i++) @(negedge clk);
    chk(!pin_dmarq, {tg, " request withdrawn"}, int'(pin_dmarq), 0);
    chk(!burst_on && !pin_data_oe, {tg, " bus released"}, int'({burst_on, pin_data_oe}), 0);
    chk((rx_cnt - rx_base) == (rd_idx - rd_base), {tg, " popped words all strobed"},
        rx_cnt - rx_base, rd_idx - rd_base);
    lvl = pin_drdy_dstb; p = rd_idx; w = wx_cnt;
    for (int i = 0; i < 6; i++) begin
      if (poke && (i % 2 == 0)) pin_hrdy_hstb = ~pin_hrdy_hstb;
      @(negedge clk);
    end
    chk(pin_drdy_dstb == lvl, {tg, " strobe frozen"}, int'(pin_drdy_dstb), int'(lvl));
    chk(rd_idx == p, {tg, " no pop after stop"}, rd_idx, p);
    chk(wx_cnt == w, "R9 no push while draining", wx_cnt, w);
    cmd_dma_active = 1'b0; int_dma_req = 1'b0; mon_rd = 1'b0;
    pin_dmack = 1'b0; pin_stop = 1'b0;
    repeat (4) @(negedge clk);
    chk(!burst_on && !pin_dmarq, "R9 back to idle", int'({burst_on, pin_dmarq}), 0);
    chk(pin_drdy_dstb == 1'b0, "R9 device pin reverted", int'(pin_drdy_dstb), 0);
  endtask

  task automatic send_word(input int k);
    pin_data_in = wrw(k);
    @(negedge clk);
    pin_hrdy_hstb = ~pin_hrdy_hstb;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lvl0, idx0, w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!pin_dmarq, "R1 reset request low", int'(pin_dmarq), 0);
    chk(!burst_on && !pin_data_oe && !pin_drdy_dstb && !wr_push, "R9 reset idle",
        int'({burst_on, pin_data_oe, pin_drdy_dstb, wr_push}), 0);

    // R10: every address value
    for (int a = 0; a < 2048; a++) begin
      addr_pin = 11'(a);
      @(negedge clk);
      chk(reg_addr == 3'(a & 7), "R10 low address bits", int'(reg_addr), a & 7);
    end

    // R1: all combinations of the three request conditions
    for (int c = 0; c < 8; c++) begin
      udma_mode_en = c[0]; cmd_dma_active = c[1]; int_dma_req = c[2];
      @(negedge clk);
      chk(pin_dmarq == (c == 7), "R1 request condition", int'(pin_dmarq), int'(c == 7));
      udma_mode_en = 1'b0; cmd_dma_active = 1'b0; int_dma_req = 1'b0;
      repeat (2) @(negedge clk);
    end

    // read burst with pause, ended by the device
    rd_base = rd_idx; rx_base = rx_cnt; rd_len = 24; pin_hrdy_hstb = 1'b1;
    enter(1'b1);
    for (int i = 0; i < 200 && (rd_idx - rd_base) < 8; i++) @(negedge clk);
    pin_hrdy_hstb = 1'b0;
    repeat (4) @(negedge clk);
    lvl0 = int'(pin_drdy_dstb); idx0 = rd_idx;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(int'(pin_drdy_dstb) == lvl0, "R4 strobe held in pause", int'(pin_drdy_dstb), lvl0);
    end
    chk(rd_idx == idx0, "R4 no pop in pause", rd_idx, idx0);
    pin_hrdy_hstb = 1'b1;
    for (int i = 0; i < 300 && (rx_cnt - rx_base) < 24; i++) @(negedge clk);
    chk((rx_cnt - rx_base) == 24, "R3 read word count", rx_cnt - rx_base, 24);
    chk((rx_cnt - rx_base) > 8, "R4 resumed after pause", rx_cnt - rx_base, 24);
    leave(1'b0, 1'b0);

    // read burst ended by the host mid-stream
    rd_base = rd_idx; rx_base = rx_cnt; rd_len = 60;
    enter(1'b1);
    for (int i = 0; i < 200 && (rd_idx - rd_base) < 10; i++) @(negedge clk);
    leave(1'b1, 1'b0);
    chk((rd_idx - rd_base) < 60, "R7 stopped before buffer end", rd_idx - rd_base, 59);

    // write burst, ready threshold sweep, device stop with strobes in drain
    w0 = wx_cnt; wr_free = 5'd16;
    enter(1'b0);
    @(negedge clk);
    chk(pin_drdy_dstb == 1'b1, "R6 ready with room", int'(pin_drdy_dstb), 1);
    for (int k = 0; k < 20; k++) send_word(w0 + k);
    repeat (4) @(negedge clk);
    chk((wx_cnt - w0) == 20, "R5 write word count", wx_cnt - w0, 20);
    for (int v = 0; v < 32; v++) begin
      wr_free = 5'(v);
      @(negedge clk);
      chk(pin_drdy_dstb == (v > 2), "R6 ready threshold", int'(pin_drdy_dstb), int'(v > 2));
    end
    wr_free = 5'd16;
    leave(1'b0, 1'b1);
    w0 = wx_cnt;
    for (int i = 0; i < 4; i++) begin
      pin_hrdy_hstb = ~pin_hrdy_hstb;
      repeat (3) @(negedge clk);
    end
    chk(wx_cnt == w0, "R9 strobe ignored when idle", wx_cnt, w0);

    // write burst ended by the host
    w0 = wx_cnt;
    enter(1'b0);
    for (int k = 0; k < 7; k++) send_word(w0 + k);
    repeat (4) @(negedge clk);
    leave(1'b1, 1'b0);
    chk((wx_cnt - w0) == 7, "R5 short write count", wx_cnt - w0, 7);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule